// File: doc/BRIEF.md
# Low-Side Channel Fault Status and Shutdown Latch

This block sits beside one low-side power switch channel and turns its raw fault comparator flags into two things: a gated drive for the power stage, and a single status bit. With no fault, the status bit mirrors the switching state, which is enable AND command. When a fault is detected, the status bit shows the opposite level. Every fault flag is brought into the clock domain through a two-flop synchroniser. Each flag then passes a digital filter that counts reference ticks. The filter length depends on the fault class: short for fast, hard faults and long for ground, supply and off-state load faults. Each filter only counts in the switching states where its fault is meaningful.

Hard faults shut the power stage off and set a fail latch. The hard faults are short circuit, overtemperature, power-ground loss while on, and clock failure while on. A PWM command must not clear this latch. The latch clears only after enable AND command has stayed low for a full hold time. A separate error-hold register keeps any indication on the status output for at least one hold time after the cause has gone. A loss of the reference clock is reported at once, without filtering, and forces the drive off.

The reference clock reaches the block as a one-cycle `ref_tick` strobe. All filter and hold lengths are counted in these ticks.

Top module: `chan_diag`

## Requirements
- R1: After reset, and with no fault present, `drive` and `status` both equal `en & cmd`. Both outputs are 0 while reset is held.
- R2: Short circuit, overtemperature and on-state open load are reported only after the synchronised flag has been high for SHORT_TICKS reference ticks while on. A pulse of 3 clocks or fewer is not reported.
- R3: Power-ground loss, signal-ground loss, supply loss and off-state open load are reported only after LONG_TICKS reference ticks. A flag lasting fewer ticks than that is not reported.
- R4: A reported error makes `status` equal to the inverse of `en & cmd`.
- R5: Once an error cause has gone, the error stays visible on `status` for HOLD_TICKS reference ticks more, then `status` returns to `en & cmd`.
- R6: A filtered short circuit, overtemperature, or power-ground loss while on sets the fail latch. The latch forces `drive` to 0, and it stays set after the fault flag drops while `en & cmd` is still high.
- R7: The fail latch clears only after `en & cmd` has been low continuously for HOLD_TICKS reference ticks. A shorter low interval leaves `drive` at 0 when the command returns high.
- R8: Signal-ground loss and supply loss invert `status` but do not set the fail latch. `drive` stays 1 while on.
- R9: An asserted `clk_fail` forces `drive` to 0 and inverts `status` within three clocks, with no filtering.
- R10: The on-state open-load flag has no effect while `en & cmd` is low. The off-state open-load flag has no effect while `en & cmd` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle strobe per reference clock period |
| en | input | 1 | Channel enable |
| cmd | input | 1 | Switching command (may be PWM) |
| flt_short | input | 1 | Raw short-circuit flag (bit 0 of the fault vector) |
| flt_otemp | input | 1 | Raw overtemperature flag (bit 1) |
| flt_pgnd | input | 1 | Raw power-ground loss flag (bit 2) |
| flt_sgnd | input | 1 | Raw signal-ground loss flag (bit 3) |
| flt_vsloss | input | 1 | Raw supply loss flag (bit 4) |
| flt_olon | input | 1 | Raw on-state open-load flag (bit 5) |
| flt_oloff | input | 1 | Raw off-state open-load flag (bit 6) |
| clk_fail | input | 1 | Reference clock failure flag from the clock watchdog |
| drive | output | 1 | Gated power-stage drive |
| status | output | 1 | Status bit: switching state, inverted on error |

## Verification
A fail latch stuck set shows as `drive` held at 0 one clock after the command rises. A latch that clears too early shows as `drive` returning after a short PWM low pulse. A filter that is too short lets a 3-clock glitch invert `status` within a few ticks. A filter that is too long leaves `status` uninverted after the full filter window. A broken error-hold register shows as `status` following `en & cmd` again long before HOLD_TICKS ticks have passed after the fault. A wrong qualification mask shows as an open-load flag inverting `status` in the state where it should be ignored.

// File: rtl/chan_diag_pkg.sv
package chan_diag_pkg;
  // number of filtered fault classes
  localparam int NFLT = 7;
  // fault vector bit positions
  localparam int B_SHORT  = 0;
  localparam int B_OTEMP  = 1;
  localparam int B_PGND   = 2;
  localparam int B_SGND   = 3;
  localparam int B_VSLOSS = 4;
  localparam int B_OLON   = 5;
  localparam int B_OLOFF  = 6;
  // class masks, indexed by bit position
  localparam logic [NFLT-1:0] M_FAST    = 7'b0100011; // short filter
  localparam logic [NFLT-1:0] M_ON_ONLY = 7'b0100011; // qualified by on
  localparam logic [NFLT-1:0] M_OFFONLY = 7'b1000000; // qualified by off
  localparam logic [NFLT-1:0] M_LATCH   = 7'b0000111; // sets fail latch when on
endpackage

// File: rtl/sync2.sv
module sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/tick_filter.sv
module tick_filter #(
  parameter int LEN = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic cond,
  output logic hit
);
  localparam int CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] TOP = CW'(LEN);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !cond) cnt <= '0;
    else if (tick && cnt != TOP) cnt <= cnt + 1'b1;
  end

  assign hit = (cnt == TOP);

  AST_FILT_CLEARS: assert property (@(posedge clk) disable iff (rst)
    !$past(cond) |-> !hit); // R2
  AST_FILT_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    $rose(hit) |-> $past(tick)); // R3
endmodule

// File: rtl/chan_diag.sv
module chan_diag
  import chan_diag_pkg::*;
#(
  parameter int SHORT_TICKS = 2,
  parameter int LONG_TICKS  = 8,
  parameter int HOLD_TICKS  = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_tick,
  input  logic en,
  input  logic cmd,
  input  logic flt_short,
  input  logic flt_otemp,
  input  logic flt_pgnd,
  input  logic flt_sgnd,
  input  logic flt_vsloss,
  input  logic flt_olon,
  input  logic flt_oloff,
  input  logic clk_fail,
  output logic drive,
  output logic status
);
  logic            on;
  logic [NFLT:0]   raw_all, sync_all;
  logic [NFLT-1:0] flt_s, filt;
  logic            clkf_s;
  logic            latch_set, fail_q, low_done;
  logic            err_active, err_q, hold_done;

  assign on = en & cmd;

  assign raw_all = {clk_fail, flt_oloff, flt_olon, flt_vsloss,
                    flt_sgnd, flt_pgnd, flt_otemp, flt_short};

  sync2 #(.W(NFLT + 1)) u_sync (
    .clk(clk), .rst(rst), .d(raw_all), .q(sync_all)
  );

  assign flt_s  = sync_all[NFLT-1:0];
  assign clkf_s = sync_all[NFLT];

  // one qualified filter per fault class
  for (genvar i = 0; i < NFLT; i++) begin : g_filt
    localparam int LEN = M_FAST[i] ? SHORT_TICKS : LONG_TICKS;
    logic qual;
    if (M_ON_ONLY[i]) begin : g_on
      assign qual = on;
    end else if (M_OFFONLY[i]) begin : g_off
      assign qual = ~on;
    end else begin : g_any
      assign qual = 1'b1;
    end
    tick_filter #(.LEN(LEN)) u_f (
      .clk(clk), .rst(rst), .tick(ref_tick),
      .cond(flt_s[i] & qual), .hit(filt[i])
    );
  end

  // fail latch with low-time release
  assign latch_set = ((|(filt & M_LATCH)) | clkf_s) & on;

  tick_filter #(.LEN(HOLD_TICKS)) u_low (
    .clk(clk), .rst(rst), .tick(ref_tick), .cond(~on), .hit(low_done)
  );

  always_ff @(posedge clk) begin
    if (rst)            fail_q <= 1'b0;
    else if (latch_set) fail_q <= 1'b1;
    else if (low_done)  fail_q <= 1'b0;
  end

  // error-hold register
  assign err_active = (|filt) | fail_q | clkf_s;

  tick_filter #(.LEN(HOLD_TICKS)) u_hold (
    .clk(clk), .rst(rst), .tick(ref_tick),
    .cond(err_q & ~err_active), .hit(hold_done)
  );

  always_ff @(posedge clk) begin
    if (rst)             err_q <= 1'b0;
    else if (err_active) err_q <= 1'b1;
    else if (hold_done)  err_q <= 1'b0;
  end

  // registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      drive  <= 1'b0;
      status <= 1'b0;
    end else begin
      drive  <= on & ~fail_q & ~latch_set & ~clkf_s;
      status <= on ^ (err_q | err_active);
    end
  end

  AST_FAIL_BLOCKS_DRIVE: assert property (@(posedge clk) disable iff (rst)
    fail_q |=> !drive); // R6
  AST_LATCH_NEEDS_ON: assert property (@(posedge clk) disable iff (rst)
    $rose(fail_q) |-> $past(on)); // R6
  AST_LATCH_STICKY: assert property (@(posedge clk) disable iff (rst)
    (fail_q && on) |=> fail_q); // R7
  AST_CLKF_BLOCKS_DRIVE: assert property (@(posedge clk) disable iff (rst)
    clkf_s |=> !drive); // R9
  AST_ERR_INVERTS: assert property (@(posedge clk) disable iff (rst)
    err_q |=> (status != $past(on))); // R4
endmodule

// File: tb/sim_chan_diag.sv
module sim_chan_diag;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_tick = 1'b0;
  logic en = 0, cmd = 0, clk_fail = 0;
  logic [6:0] flt = '0;
  logic drive, status;
  int checks = 0, failures = 0;
  int tdiv = 0;

  always #4 clk = ~clk;

  // reference tick every 4 clocks
  always @(posedge clk) begin
    tdiv     <= (tdiv == 3) ? 0 : tdiv + 1;
    ref_tick <= (tdiv == 3);
  end

  chan_diag u0 (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .en(en), .cmd(cmd),
    .flt_short(flt[0]), .flt_otemp(flt[1]), .flt_pgnd(flt[2]),
    .flt_sgnd(flt[3]), .flt_vsloss(flt[4]), .flt_olon(flt[5]),
    .flt_oloff(flt[6]), .clk_fail(clk_fail), .drive(drive), .status(status)
  );

  // {en, cmd, flt[6:0], clk_fail, wait[11:0], exp_drive, exp_status}
  localparam int NV = 7;
  localparam logic [23:0] VEC [NV] = '{
    {1'b0, 1'b0, 7'b0000000, 1'b0, 12'd10, 1'b0, 1'b0}, // R1
    {1'b1, 1'b0, 7'b0000000, 1'b0, 12'd10, 1'b0, 1'b0}, // R1
    {1'b0, 1'b1, 7'b0000000, 1'b0, 12'd10, 1'b0, 1'b0}, // R1
    {1'b1, 1'b1, 7'b0000000, 1'b0, 12'd10, 1'b1, 1'b1}, // R1
    {1'b1, 1'b0, 7'b0100000, 1'b0, 12'd60, 1'b0, 1'b0}, // R10 olon while off
    {1'b1, 1'b1, 7'b1000000, 1'b0, 12'd60, 1'b1, 1'b1}, // R10 oloff while on
    {1'b1, 1'b1, 7'b0100000, 1'b0, 12'd40, 1'b1, 1'b0}  // R2 R4 olon while on
  };

  task automatic chk(input string req, input string what,
                     input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; en = 0; cmd = 0; flt = '0; clk_fail = 0;
    cyc(4);
    rst = 0;
    cyc(1);
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    cyc(3);
    chk("R1", "drive in reset", drive, 1'b0);
    chk("R1", "status in reset", status, 1'b0);
    rst = 0;
    cyc(1);

    for (int i = 0; i < NV; i++) begin
      en = VEC[i][23]; cmd = VEC[i][22]; flt = VEC[i][21:15];
      clk_fail = VEC[i][14];
      cyc(int'(VEC[i][13:2]));
      chk("R1 R2 R4 R10 table", "drive", drive, VEC[i][1]);
      chk("R1 R2 R4 R10 table", "status", status, VEC[i][0]);
    end

    // R2: short glitch ignored, held short latches (R6)
    do_reset();
    en = 1; cmd = 1;
    cyc(5);
    flt[0] = 1; cyc(3); flt[0] = 0;
    cyc(20);
    chk("R2", "status after short glitch", status, 1'b1);
    chk("R2", "drive after short glitch", drive, 1'b1);
    flt[0] = 1; cyc(20);
    chk("R2", "status with held short", status, 1'b0);
    chk("R6", "drive with held short", drive, 1'b0);
    flt[0] = 0; cyc(100);
    chk("R6", "drive stays latched", drive, 1'b0);
    // R7: short low pulse does not clear
    cmd = 0; cyc(200);
    chk("R4", "status inverted while off", status, 1'b1);
    cmd = 1; cyc(10);
    chk("R7", "drive after short low", drive, 1'b0);
    cmd = 0; cyc(1100);
    cmd = 1; cyc(10);
    chk("R7", "drive after long low", drive, 1'b1);
    chk("R5", "error still held", status, 1'b0);
    cyc(1100);
    chk("R5", "error hold expired", status, 1'b1);

    // R3 and R8: signal-ground loss
    do_reset();
    en = 1; cmd = 1; cyc(5);
    flt[3] = 1; cyc(16); flt[3] = 0;
    cyc(10);
    chk("R3", "status after short sgnd", status, 1'b1);
    flt[3] = 1; cyc(60);
    chk("R3", "status with held sgnd", status, 1'b0);
    chk("R8", "drive with sgnd", drive, 1'b1);
    flt[3] = 0; cyc(60);
    chk("R5", "sgnd error held", status, 1'b0);

    // R8: supply loss does not latch
    do_reset();
    en = 1; cmd = 1; cyc(5);
    flt[4] = 1; cyc(60);
    chk("R8", "drive with vsloss", drive, 1'b1);
    chk("R8", "status with vsloss", status, 1'b0);

    // R6: power-ground loss while on latches
    do_reset();
    en = 1; cmd = 1; cyc(5);
    flt[2] = 1; cyc(60);
    flt[2] = 0; cyc(20);
    chk("R6", "drive after pgnd", drive, 1'b0);

    // R6: overtemperature
    do_reset();
    en = 1; cmd = 1; cyc(5);
    flt[1] = 1; cyc(20);
    chk("R6", "drive with otemp", drive, 1'b0);

    // R3: off-state open load uses long filter
    do_reset();
    en = 1; cmd = 0; cyc(5);
    flt[6] = 1; cyc(16);
    chk("R3", "oloff before long filter", status, 1'b0);
    cyc(44);
    chk("R3", "oloff after long filter", status, 1'b1);

    // R9: clock failure
    do_reset();
    en = 1; cmd = 0; cyc(5);
    clk_fail = 1; cyc(4);
    chk("R9", "status on clock fail off", status, 1'b1);
    cmd = 1; cyc(2);
    chk("R9", "drive on clock fail", drive, 1'b0);
    chk("R9", "status on clock fail on", status, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule